// File: doc/BRIEF.md
# Approximate Pattern-Match Bit Correlator

This block watches a serial bit stream, one bit per clock qualified by a valid strobe, and measures how closely the most recent window of received bits agrees with a fixed binary training pattern. The pattern is a build-time parameter. The window is cut into groups of four bits. Each group's agreement count is reduced before a pipelined adder tree sums the groups into a score. The score is sent out together with a valid flag, and a detect flag goes high when the score is strictly above a threshold supplied at run time. A receiver uses the detect flag to find frame or symbol timing in a noisy stream.

By default each group's count of agreeing bits is replaced by that count minus one, floored at zero. This fits in two bits instead of three and makes the adder tree narrower. A build parameter selects the exact per-group count instead. The approximate mode cannot tell a group with zero agreements from a group with one. A well-aligned but noisy pattern almost never produces such groups, so detection suffers very little.

Top module: `approx_bit_corr`

## Requirements
- R1: On every clock with `valid_i` high, `bit_i` enters window position 0 and every older bit moves up one position, so window position k holds the bit received k valid cycles earlier. A clock with `valid_i` low leaves the window unchanged and produces no scored output.
- R2: Window position k is compared with bit k of `PATTERN` and counts as an agreement when the two are equal. Sending `PATTERN[WIN_LEN-1]` first and `PATTERN[0]` last therefore aligns the whole pattern.
- R3: Group g covers window positions 4g to 4g+3. With `APPROX`=1 a group holding m agreements contributes max(0, m-1), so m=0 and m=1 both contribute 0.
- R4: With `APPROX`=0 a group contributes m, and the score ranges from 0 to `WIN_LEN`.
- R5: The score is the sum of all group contributions. With `APPROX`=1 it ranges from 0 to 3·`WIN_LEN`/4.
- R6: `score_valid_o` is high exactly ceil(log2(`WIN_LEN`/4))+2 cycles after a cycle with `valid_i` high, and `score_o` then reflects the window that includes that bit. Other cycles have `score_valid_o` low.
- R7: `detect_o` is high in a cycle only if `score_valid_o` is high and `score_o` is strictly greater than `thr_i` in that same cycle. A score equal to the threshold does not detect.
- R8: A synchronous, active-high `rst_i` clears the window to all zeros and clears all output flags. `detect_o` stays low for any score whose window holds fewer than `WIN_LEN` bits received since reset.

Block parameters: `WIN_LEN` must be a multiple of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Received bit |
| valid_i | input | 1 | `bit_i` carries a new bit this cycle |
| thr_i | input | SCORE_W | Detection threshold, compared strictly |
| score_o | output | SCORE_W | Match score of the window |
| score_valid_o | output | 1 | `score_o` belongs to a received bit |
| detect_o | output | 1 | Score above threshold on a full window |

## Verification
Two cases are hard to reach from the ports. The first is a score landing exactly on the threshold. The second is a group holding exactly one agreement, which the approximate mode must merge with zero. The bench handles both by feeding the pattern in with a chosen number of flipped bits, spread across groups, interleaved with pseudo-random filler and gaps in valid. The threshold steps through every value in the score range, so equality turns up many times against both the approximate and the exact build. A clean pattern is also sent right after reset with a zero threshold, while the all-zero reset window already partly matches. This checks that detection waits for a full window.

// File: rtl/bcorr_pkg.sv
package bcorr_pkg;

    // Flags that travel down the pipeline beside the data.
    typedef struct packed {
        logic vld;
        logic primed;
    } tag_t;

    // Contribution of one four-bit group: agreements, or agreements-1 floored at 0.
    function automatic logic [2:0] grp_value(input logic [3:0] w,
                                             input logic [3:0] p,
                                             input logic       approx);
        logic [3:0] m;
        logic [2:0] c;
        m = ~(w ^ p);
        c = {2'b00, m[0]} + {2'b00, m[1]} + {2'b00, m[2]} + {2'b00, m[3]};
        if (approx && (c != 3'd0)) begin
            c = c - 3'd1;
        end
        return c;
    endfunction

endpackage

// File: rtl/bcorr_window.sv
module bcorr_window #(
    parameter int unsigned WIN_LEN = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bit_i,
    input  logic               valid_i,
    output logic [WIN_LEN-1:0] win_o,
    output logic               near_full_o
);
    localparam int unsigned FILL_W = $clog2(WIN_LEN + 1);

    typedef struct packed {
        logic [WIN_LEN-1:0] win;
        logic [FILL_W-1:0]  fill;
    } win_state_t;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid_i) begin
            st_d.win = {st_q.win[WIN_LEN-2:0], bit_i};
            if (st_q.fill != FILL_W'(WIN_LEN)) begin
                st_d.fill = st_q.fill + FILL_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_o       = st_q.win;
    // The bit arriving now completes a full window.
    assign near_full_o = (st_q.fill >= FILL_W'(WIN_LEN - 1));

    // R1: a valid bit lands at position 0 and the rest move up by one
    a_r1_shift_in : assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> (win_o[0] == $past(bit_i)) &&
                    (win_o[WIN_LEN-1:1] == $past(win_o[WIN_LEN-2:0])));

    // R1: without a valid bit the window holds
    a_r1_hold : assert property (@(posedge clk_i) disable iff (rst_i)
        !valid_i |=> $stable(win_o));

endmodule

// File: rtl/bcorr_groups.sv
module bcorr_groups #(
    parameter int unsigned       WIN_LEN = 16,
    parameter logic [WIN_LEN-1:0] PATTERN = '0,
    parameter bit                APPROX  = 1'b1
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic [WIN_LEN-1:0]          win_i,
    output logic [(WIN_LEN/4)*(APPROX ? 2 : 3)-1:0] grp_o
);
    localparam int unsigned GROUPS = WIN_LEN / 4;
    localparam int unsigned GV_W   = APPROX ? 2 : 3;
    localparam int unsigned GRP_W  = GROUPS * GV_W;

    logic [GRP_W-1:0] grp_d, grp_q;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_d[g*GV_W +: GV_W] =
            GV_W'(bcorr_pkg::grp_value(win_i[4*g +: 4], PATTERN[4*g +: 4], APPROX));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            grp_q <= '0;
        end else begin
            grp_q <= grp_d;
        end
    end

    assign grp_o = grp_q;

    // R3: a group that fully agrees in the window yields the top value next cycle
    a_r3_full_group : assert property (@(posedge clk_i) disable iff (rst_i)
        (win_i[3:0] == PATTERN[3:0]) |=> (grp_o[GV_W-1:0] == GV_W'(APPROX ? 3 : 4)));

endmodule

// File: rtl/bcorr_tree.sv
module bcorr_tree #(
    parameter int unsigned GROUPS  = 4,
    parameter int unsigned GV_W    = 2,
    parameter int unsigned SCORE_W = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic [GROUPS*GV_W-1:0]    grp_i,
    output logic [SCORE_W-1:0]        sum_o
);
    localparam int unsigned LVLS = $clog2(GROUPS);
    localparam int unsigned NPAD = 1 << LVLS;

    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int unsigned NN = NPAD >> l;
        logic [SCORE_W-1:0] node [NN];

        if (l == 0) begin : g_leaf
            for (genvar i = 0; i < NN; i++) begin : g_in
                if (i < GROUPS) begin : g_use
                    assign node[i] = SCORE_W'(grp_i[i*GV_W +: GV_W]);
                end else begin : g_pad
                    assign node[i] = '0;
                end
            end
        end else begin : g_add
            logic [SCORE_W-1:0] node_d [NN];

            always_comb begin
                for (int i = 0; i < NN; i++) begin
                    node_d[i] = g_lvl[l-1].node[2*i] + g_lvl[l-1].node[2*i+1];
                end
            end

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    node <= '{default: '0};
                end else begin
                    node <= node_d;
                end
            end
        end
    end

    assign sum_o = g_lvl[LVLS].node[0];

endmodule

// File: rtl/approx_bit_corr.sv
module approx_bit_corr #(
    parameter int unsigned        WIN_LEN = 16,
    parameter logic [WIN_LEN-1:0] PATTERN = 16'hB38E,
    parameter bit                 APPROX  = 1'b1,
    localparam int unsigned       SCORE_MAX = APPROX ? (3 * WIN_LEN / 4) : WIN_LEN,
    localparam int unsigned       SCORE_W   = $clog2(SCORE_MAX + 1)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               bit_i,
    input  logic               valid_i,
    input  logic [SCORE_W-1:0] thr_i,
    output logic [SCORE_W-1:0] score_o,
    output logic               score_valid_o,
    output logic               detect_o
);
    import bcorr_pkg::*;

    localparam int unsigned GROUPS = WIN_LEN / 4;
    localparam int unsigned GV_W   = APPROX ? 2 : 3;
    localparam int unsigned LVLS   = $clog2(GROUPS);
    localparam int unsigned LAT    = LVLS + 2;
    localparam int unsigned FILL_W = $clog2(WIN_LEN + 1);

    logic [WIN_LEN-1:0]     win;
    logic                   near_full;
    logic [GROUPS*GV_W-1:0] grp;
    logic [SCORE_W-1:0]     sum;

    bcorr_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .bit_i       (bit_i),
        .valid_i     (valid_i),
        .win_o       (win),
        .near_full_o (near_full)
    );

    bcorr_groups #(.WIN_LEN(WIN_LEN), .PATTERN(PATTERN), .APPROX(APPROX)) u_groups (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .win_i (win),
        .grp_o (grp)
    );

    bcorr_tree #(.GROUPS(GROUPS), .GV_W(GV_W), .SCORE_W(SCORE_W)) u_tree (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .grp_i (grp),
        .sum_o (sum)
    );

    // Flag pipeline, one stage per data register on the way to score_o.
    tag_t tag_d [LAT];
    tag_t tag_q [LAT];

    always_comb begin
        tag_d[0].vld    = valid_i;
        tag_d[0].primed = valid_i & near_full;
        for (int i = 1; i < LAT; i++) begin
            tag_d[i] = tag_q[i-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tag_q <= '{default: '0};
        end else begin
            tag_q <= tag_d;
        end
    end

    assign score_o       = sum;
    assign score_valid_o = tag_q[LAT-1].vld;
    assign detect_o      = tag_q[LAT-1].vld & tag_q[LAT-1].primed & (sum > thr_i);

    // Checker state: valid bits seen since reset, saturating at the window length.
    logic [FILL_W-1:0] chk_cnt_d, chk_cnt_q;

    always_comb begin
        chk_cnt_d = chk_cnt_q;
        if (valid_i && (chk_cnt_q != FILL_W'(WIN_LEN))) begin
            chk_cnt_d = chk_cnt_q + FILL_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chk_cnt_q <= '0;
        end else begin
            chk_cnt_q <= chk_cnt_d;
        end
    end

    // R5 / R4: a valid score never leaves its range
    a_r5_score_range : assert property (@(posedge clk_i) disable iff (rst_i)
        score_valid_o |-> (score_o <= SCORE_W'(SCORE_MAX)));

    // R7: detection only ever accompanies a valid score
    a_r7_detect_valid : assert property (@(posedge clk_i) disable iff (rst_i)
        detect_o |-> score_valid_o);

    // R8: no detection before a whole window has been received
    a_r8_primed : assert property (@(posedge clk_i) disable iff (rst_i)
        detect_o |-> (chk_cnt_q == FILL_W'(WIN_LEN)));

    // R6: an output valid needs at least one input valid since reset
    a_r6_valid_source : assert property (@(posedge clk_i) disable iff (rst_i)
        score_valid_o |-> (chk_cnt_q != '0));

endmodule

// File: tb/approx_bit_corr_tb.sv
module approx_bit_corr_tb_top;

    localparam int unsigned N     = 16;
    localparam logic [N-1:0] PAT  = 16'hB38E;
    localparam int unsigned LAT   = $clog2(N / 4) + 2;
    localparam int unsigned MAX_A = 3 * N / 4;
    localparam int unsigned MAX_X = N;

    logic       clk = 1'b0;
    logic       rst_i = 1'b1;
    logic       bit_i = 1'b0;
    logic       valid_i = 1'b0;
    logic [3:0] thr_a = '0;
    logic [4:0] thr_x = '0;
    logic [3:0] score_a;
    logic [4:0] score_x;
    logic       sv_a, sv_x, det_a, det_x;

    always #5 clk = ~clk;

    approx_bit_corr #(.WIN_LEN(N), .PATTERN(PAT), .APPROX(1'b1)) dut_i (
        .clk_i(clk), .rst_i(rst_i), .bit_i(bit_i), .valid_i(valid_i), .thr_i(thr_a),
        .score_o(score_a), .score_valid_o(sv_a), .detect_o(det_a));

    approx_bit_corr #(.WIN_LEN(N), .PATTERN(PAT), .APPROX(1'b0)) dut_x (
        .clk_i(clk), .rst_i(rst_i), .bit_i(bit_i), .valid_i(valid_i), .thr_i(thr_x),
        .score_o(score_x), .score_valid_o(sv_x), .detect_o(det_x));

    int checks = 0;
    int errors = 0;
    int eq_hits = 0;
    bit finished = 1'b0;

    typedef struct {
        bit vld;
        bit prim;
        int sa;
        int sx;
    } exp_t;

    exp_t        ring [16];
    logic [N-1:0] sw;
    int          fill;
    int          edge_n;
    logic [31:0] rng = 32'h1F2E3D4C;

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // R2 R3 R4 R5: score computed from the requirements
    function automatic int model_score(input logic [N-1:0] w, input bit approx);
        int total;
        total = 0;
        for (int g = 0; g < N / 4; g++) begin
            int m;
            m = 0;
            for (int b = 0; b < 4; b++) begin
                if (w[4*g+b] == PAT[4*g+b]) m++;
            end
            if (approx) total += (m > 0) ? m - 1 : 0;
            else        total += m;
        end
        return total;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edge_n);
        end
    endtask

    task automatic check_outputs();
        int idx;
        exp_t e;
        idx = edge_n - int'(LAT) + 1;
        if (idx >= 1) e = ring[idx % 16];
        else begin
            e.vld = 0; e.prim = 0; e.sa = 0; e.sx = 0;
        end
        check(sv_a == e.vld, "R6 valid approx", int'(sv_a), int'(e.vld));
        check(sv_x == e.vld, "R6 valid exact", int'(sv_x), int'(e.vld));
        if (e.vld) begin
            check(int'(score_a) == e.sa, "R3 R5 approx score", int'(score_a), e.sa);
            check(int'(score_x) == e.sx, "R4 exact score", int'(score_x), e.sx);
            if (e.prim && (e.sa == int'(thr_a))) eq_hits++;
        end
        check(det_a == (e.vld && e.prim && (e.sa > int'(thr_a))), "R7 R8 detect approx",
              int'(det_a), int'(e.vld && e.prim && (e.sa > int'(thr_a))));
        check(det_x == (e.vld && e.prim && (e.sx > int'(thr_x))), "R7 R8 detect exact",
              int'(det_x), int'(e.vld && e.prim && (e.sx > int'(thr_x))));
    endtask

    // R1: model window shifts only on valid
    task automatic step(input logic b, input logic v);
        exp_t e;
        bit_i   = b;
        valid_i = v;
        edge_n++;
        e.prim = 0;
        if (v) begin
            e.prim = (fill >= int'(N) - 1);
            sw = {sw[N-2:0], b};
            if (fill < int'(N)) fill++;
        end
        e.vld = v;
        e.sa  = model_score(sw, 1'b1);
        e.sx  = model_score(sw, 1'b0);
        ring[edge_n % 16] = e;
        @(negedge clk);
        check_outputs();
    endtask

    // R8: reset state
    task automatic do_reset();
        rst_i   = 1'b1;
        valid_i = 1'b0;
        repeat (3) @(negedge clk);
        check(sv_a == 1'b0 && sv_x == 1'b0, "R8 reset valid", int'(sv_a | sv_x), 0);
        check(det_a == 1'b0 && det_x == 1'b0, "R8 reset detect", int'(det_a | det_x), 0);
        rst_i  = 1'b0;
        sw     = '0;
        fill   = 0;
        edge_n = 0;
    endtask

    task automatic send_pattern(input int errs, input int seed);
        logic [N-1:0] p;
        p = PAT;
        for (int t = 0; t < errs; t++) begin
            p[(seed * 5 + t * 7) % N] = ~p[(seed * 5 + t * 7) % N];
        end
        // R2: most significant pattern bit goes first
        for (int k = N - 1; k >= 0; k--) step(p[k], 1'b1);
    endtask

    initial begin
        #(10 * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R8: zero threshold, clean pattern straight after reset
        thr_a = '0;
        thr_x = '0;
        send_pattern(0, 0);
        for (int k = 0; k < int'(LAT); k++) step(1'b0, 1'b0);

        // Sweep: pattern with 0..4 flipped bits, random filler, valid gaps,
        // threshold stepping over the full score range (R3 R4 R5 R6 R7).
        for (int rep = 0; rep < 80; rep++) begin
            thr_a = 4'(rep % (MAX_A + 1));
            thr_x = 5'(rep % (MAX_X + 1));
            send_pattern(rep % 5, rep);
            for (int k = 0; k < 10; k++) begin
                rng = next_rng(rng);
                step(rng[0], (rng[7:5] != 3'd0));
            end
        end

        // R1: long gap in valid, window must stay put
        send_pattern(0, 1);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);

        // R8: reset mid-stream, then priming again
        do_reset();
        thr_a = '0;
        thr_x = '0;
        for (int k = 0; k < 3; k++) send_pattern(k, k + 3);
        for (int k = 0; k < int'(LAT); k++) step(1'b0, 1'b0);

        checks++;
        if (eq_hits == 0) begin
            errors++;
            $display("FAIL R7 score-equals-threshold case never reached actual=0 expected>0");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule